// File: doc/BRIEF.md
# Secured Fuse-Pattern Store

This block holds the configuration pattern of a programmable logic array as a set of rows and serves a programmer port. The port supports whole-pattern erase, row programming, row readback and a one-way lock. Every stored bit drives the logic array directly through a flat configuration bus. A second output, a preload-enable flag, tells the array's test-load path whether it may force register states.

An erased cell holds 1. Programming can only clear bits: each 0 in the write data clears the matching cell, and each 1 leaves it as it is. A programming pass starts with the first row write after reset, after a readback or after the lock command. Before that write takes effect, the block erases the whole pattern on its own, so the programmer never has to issue an erase. Setting the lock hides the pattern from readback, so every row reads as erased, and it withdraws preload permission. From then on, row writes have no effect. Only a whole-pattern erase removes the lock. The configuration bus keeps showing the real stored pattern in every state.

Top module: `cfg_vault`

## Requirements
- R1: While reset is held, and directly after it, busy and rd_valid are 0, preload_en is 1 and every configuration bit is 1.
- R2: A write (cmd_op 2'd1) inside an open pass changes only the addressed row, to old_row AND cmd_data. Busy is high for exactly 1 cycle.
- R3: The first write after reset, after a read or after a lock command, with the lock clear, first sets every row to all ones and then applies the write. Busy is high for NROWS+1 cycles, and the pass is then open.
- R4: An erase command (cmd_op 2'd0) sets every row to all ones, clears the lock and opens a pass. Busy is high for exactly NROWS cycles.
- R5: A read command (cmd_op 2'd2) holds busy for 1 cycle. In the cycle after busy falls, rd_valid is high for that one cycle only, and rd_data holds the addressed row. A read closes the pass.
- R6: While the lock is set, every read returns all ones, whatever the row holds.
- R7: The lock command (cmd_op 2'd3) sets the lock, closes the pass and holds busy for 1 cycle. preload_en is 0 exactly while the lock is set.
- R8: While the lock is set, a write holds busy for 1 cycle and changes no configuration bit. It also starts no automatic erase.
- R9: A command presented while busy is high is dropped. It has no effect when the running command finishes, and nothing is replayed afterwards.
- R10: cfg_bits always carries the stored pattern, with row r in bits [r*DATA_W +: DATA_W], including while the lock is set.
- R11: Reads and writes never clear the lock. Only an erase clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 erase, 1 write, 2 read, 3 lock |
| cmd_addr | input | ADDR_W | Row address for write and read |
| cmd_data | input | DATA_W | Write data; 0 bits clear cells |
| busy | output | 1 | High while a command executes |
| rd_valid | output | 1 | One-cycle readback strobe |
| rd_data | output | DATA_W | Readback row, all ones while locked |
| preload_en | output | 1 | Register preload permitted (lock clear) |
| cfg_bits | output | NROWS*DATA_W | Stored pattern to the logic array |

## Verification
The hardest state to reach is a locked store whose rows are not erased. Only that state shows that readback masking, the ignored writes and the untouched configuration bus all hold at once. To reach it, the stimulus opens a pass, programs rows away from all ones and then locks. It then reads and writes through the lock and ends it with an erase. Random command streams with a fixed seed revisit this path many times. A lock command often lands after partly programmed passes, and the streams mix in writes that follow a read, so the automatic erase keeps firing. A directed sequence also strobes a write in the middle of an erase sweep.

// File: rtl/cfgv_pkg.sv
package cfgv_pkg;
  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_LOCK  = 2'd3
  } cfgv_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_LOCK  = 3'd4
  } cfgv_st_e;
endpackage

// File: rtl/cfgv_seq.sv
module cfgv_seq
  import cfgv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              locked_i,
  input  logic              pass_open_i,
  output logic              busy_o,
  output logic              in_erase_o,
  output logic              erase_en_o,
  output logic [ADDR_W-1:0] erase_row_o,
  output logic              erase_done_o,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              lock_set_o,
  output logic              pass_end_o
);
  localparam logic [ADDR_W-1:0] LAST_ROW = '1;

  cfgv_st_e          state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              chain_q, chain_d;
  logic              load_cmd;
  cfgv_op_e          op;

  assign op = cfgv_op_e'(cmd_op_i);

  // next-state logic
  always_comb begin
    state_d      = state_q;
    ptr_d        = ptr_q;
    chain_d      = chain_q;
    load_cmd     = 1'b0;
    erase_en_o   = 1'b0;
    erase_done_o = 1'b0;
    wr_en_o      = 1'b0;
    rd_en_o      = 1'b0;
    lock_set_o   = 1'b0;
    pass_end_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          load_cmd = 1'b1;
          unique case (op)
            OP_ERASE: begin
              state_d = ST_ERASE;
              chain_d = 1'b0;
              ptr_d   = '0;
            end
            OP_WRITE: begin
              if (!locked_i && !pass_open_i) begin
                state_d = ST_ERASE;
                chain_d = 1'b1;
                ptr_d   = '0;
              end else begin
                state_d = ST_WRITE;
              end
            end
            OP_READ:  state_d = ST_READ;
            OP_LOCK:  state_d = ST_LOCK;
            default:  state_d = ST_IDLE;
          endcase
        end
      end
      ST_ERASE: begin
        erase_en_o = 1'b1;
        if (ptr_q == LAST_ROW) begin
          erase_done_o = 1'b1;
          ptr_d        = '0;
          chain_d      = 1'b0;
          state_d      = chain_q ? ST_WRITE : ST_IDLE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      ST_WRITE: begin
        wr_en_o = 1'b1;
        state_d = ST_IDLE;
      end
      ST_READ: begin
        rd_en_o    = 1'b1;
        pass_end_o = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_LOCK: begin
        lock_set_o = 1'b1;
        pass_end_o = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      chain_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      chain_q <= chain_d;
      if (load_cmd) begin
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign in_erase_o  = (state_q == ST_ERASE);
  assign erase_row_o = ptr_q;
  assign addr_o      = addr_q;
  assign data_o      = data_q;

  // R3: a write that opens a pass goes into the erase sweep first
  a_r3_auto_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_valid_i && cmd_op_i == 2'd1 && !locked_i && !pass_open_i)
      |=> (state_q == ST_ERASE && ptr_q == '0));

  // R4: the sweep only ends after the last row
  a_r4_sweep_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE) |=> (state_q == ST_ERASE) || ($past(ptr_q) == LAST_ROW));

  // R9: a strobe during busy does not disturb the latched command
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_valid_i) |=> $stable(addr_q) && $stable(data_q));
endmodule

// File: rtl/cfgv_lock.sv
module cfgv_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set_i,
  input  logic erase_done_i,
  input  logic pass_end_i,
  input  logic in_erase_i,
  output logic locked_o,
  output logic pass_open_o,
  output logic preload_en_o
);
  logic locked_q, locked_d;
  logic pass_q, pass_d;

  always_comb begin
    locked_d = locked_q;
    pass_d   = pass_q;
    if (erase_done_i) begin
      locked_d = 1'b0;
      pass_d   = 1'b1;
    end else begin
      if (lock_set_i) locked_d = 1'b1;
      if (pass_end_i) pass_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      locked_q <= locked_d;
      pass_q   <= pass_d;
    end
  end

  assign locked_o     = locked_q;
  assign pass_open_o  = pass_q;
  assign preload_en_o = ~locked_q;

  // R11: the lock only falls at the end of an erase sweep
  a_r11_unlock_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(in_erase_i));

  // R7: the lock only rises on the lock command
  a_r7_lock_by_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(lock_set_i));
endmodule

// File: rtl/cfgv_array.sv
module cfgv_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int NROWS = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    erase_en_i,
  input  logic [ADDR_W-1:0]       erase_row_i,
  input  logic                    wr_en_i,
  input  logic                    lock_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W-1:0]       row_o,
  output logic [NROWS*DATA_W-1:0] cfg_o
);
  for (genvar g = 0; g < NROWS; g++) begin : g_row
    logic [DATA_W-1:0] cell_q, cell_d;
    logic              cell_en;

    always_comb begin
      cell_en = 1'b0;
      cell_d  = cell_q;
      if (erase_en_i && erase_row_i == ADDR_W'(g)) begin
        cell_en = 1'b1;
        cell_d  = '1;
      end else if (wr_en_i && !lock_i && addr_i == ADDR_W'(g)) begin
        cell_en = 1'b1;
        cell_d  = cell_q & data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '1;
      end else if (cell_en) begin
        cell_q <= cell_d;
      end
    end

    assign cfg_o[g*DATA_W +: DATA_W] = cell_q;
  end

  always_comb begin
    row_o = '1;
    for (int r = 0; r < NROWS; r++) begin
      if (addr_i == ADDR_W'(r)) row_o = cfg_o[r*DATA_W +: DATA_W];
    end
  end

  // R8: no cell moves while locked unless a sweep runs
  a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !erase_en_i) |=> $stable(cfg_o));

  // R2: a row write can only clear bits
  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_en_i) |=> ((cfg_o & ~$past(cfg_o)) == '0));
endmodule

// File: rtl/cfgv_readport.sv
module cfgv_readport #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] row_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = lock_i ? {DATA_W{1'b1}} : row_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '1;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= data_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  // R5: the readback strobe lasts a single cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/cfg_vault.sv
module cfg_vault
  import cfgv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int NROWS = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [DATA_W-1:0]       cmd_data,
  output logic                    busy,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    preload_en,
  output logic [NROWS*DATA_W-1:0] cfg_bits
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              locked, pass_open, in_erase;
  logic              erase_en, erase_done, wr_en, rd_en, lock_set, pass_end;
  logic [ADDR_W-1:0] erase_row, op_addr;
  logic [DATA_W-1:0] op_data, sel_row;

  cfgv_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_addr_i   (cmd_addr),
    .cmd_data_i   (cmd_data),
    .locked_i     (locked),
    .pass_open_i  (pass_open),
    .busy_o       (busy),
    .in_erase_o   (in_erase),
    .erase_en_o   (erase_en),
    .erase_row_o  (erase_row),
    .erase_done_o (erase_done),
    .wr_en_o      (wr_en),
    .rd_en_o      (rd_en),
    .addr_o       (op_addr),
    .data_o       (op_data),
    .lock_set_o   (lock_set),
    .pass_end_o   (pass_end)
  );

  cfgv_lock u_lock (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .lock_set_i   (lock_set),
    .erase_done_i (erase_done),
    .pass_end_i   (pass_end),
    .in_erase_i   (in_erase),
    .locked_o     (locked),
    .pass_open_o  (pass_open),
    .preload_en_o (preload_en)
  );

  cfgv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .erase_en_i  (erase_en),
    .erase_row_i (erase_row),
    .wr_en_i     (wr_en),
    .lock_i      (locked),
    .addr_i      (op_addr),
    .data_i      (op_data),
    .row_o       (sel_row),
    .cfg_o       (cfg_bits)
  );

  cfgv_readport #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_en_i    (rd_en),
    .lock_i     (locked),
    .row_i      (sel_row),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  // R6: a readback taken while preload is withheld shows erased cells
  a_r6_masked_readback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && !preload_en) |-> (&rd_data));

  // R1: nothing is busy or strobed while reset holds
  a_r1_reset_quiet: assert property (@(posedge clk)
    (!rst_sync_n) |-> (!busy && !rd_valid && preload_en));
endmodule

// File: tb/cfg_vault_test.sv
`timescale 1ns/1ps
module cfg_vault_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NR = 1 << AW;
  localparam logic [1:0] C_ERASE = 2'd0, C_WRITE = 2'd1, C_READ = 2'd2, C_LOCK = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic busy, rd_valid, preload_en;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] cfg_bits;

  always #2.5 clk = ~clk;

  cfg_vault #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .preload_en(preload_en), .cfg_bits(cfg_bits)
  );

  int total = 0;
  int bad = 0;

  logic [DW-1:0] m_row [NR];
  bit m_lock;
  bit m_pass;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    int bad_r = -1;
    for (int r = 0; r < NR; r++)
      if (bad_r < 0 && cfg_bits[r*DW +: DW] !== m_row[r]) bad_r = r;
    if (bad_r < 0) chk(1'b1, req, "cfg_bits", 0, 0);
    else chk(1'b0, req, $sformatf("cfg_bits row %0d", bad_r),
             32'(cfg_bits[bad_r*DW +: DW]), 32'(m_row[bad_r]));
  endtask

  function automatic string pick_tag(input logic [1:0] op);
    case (op)
      C_ERASE: return "R4";
      C_WRITE: return m_lock ? "R8" : (m_pass ? "R2" : "R3");
      C_READ:  return m_lock ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic model_erase();
    for (int r = 0; r < NR; r++) m_row[r] = '1;
    m_lock = 1'b0;
    m_pass = 1'b1;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    int exp_busy, n;
    bit exp_rv;
    logic [DW-1:0] exp_rd;
    exp_rv = 1'b0;
    exp_rd = '0;
    case (op)
      C_ERASE: begin model_erase(); exp_busy = NR; end
      C_WRITE: begin
        if (m_lock) exp_busy = 1;
        else begin
          if (!m_pass) begin model_erase(); exp_busy = NR + 1; end
          else exp_busy = 1;
          m_row[a] = m_row[a] & d;
        end
      end
      C_READ: begin
        exp_busy = 1; exp_rv = 1'b1;
        exp_rd = m_lock ? '1 : m_row[a];
        m_pass = 1'b0;
      end
      default: begin exp_busy = 1; m_lock = 1'b1; m_pass = 1'b0; end
    endcase
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == exp_busy, tag, "busy cycles", n, exp_busy);
    chk(rd_valid == exp_rv, "R5", "rd_valid", rd_valid, exp_rv);
    if (exp_rv) chk(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
    chk_cfg((tag == "R6" || tag == "R8") ? "R10" : tag);
    chk(preload_en == !m_lock, "R7", "preload_en", preload_en, !m_lock);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    for (int r = 0; r < NR; r++) m_row[r] = '1;
    m_lock = 1'b0; m_pass = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
    chk(preload_en == 1'b1, "R1", "preload_en", preload_en, 1);
    chk_cfg("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && preload_en == 1'b1, "R1", "after release", {busy, preload_en}, 2'b01);

    // R3 first write auto-erases, R2 AND semantics
    do_op(C_WRITE, 4'd3, 8'h0F, "R3");
    do_op(C_WRITE, 4'd3, 8'hF0, "R2");
    do_op(C_WRITE, 4'd7, 8'h5A, "R2");
    do_op(C_READ, 4'd3, 8'h00, "R5");
    do_op(C_WRITE, 4'd5, 8'hAA, "R3");
    // lock path: R7, R6, R10, R8, R11
    do_op(C_LOCK, 4'd0, 8'h00, "R7");
    do_op(C_READ, 4'd5, 8'h00, "R6");
    chk(cfg_bits[5*DW +: DW] == 8'hAA, "R10", "locked row 5", cfg_bits[5*DW +: DW], 8'hAA);
    do_op(C_WRITE, 4'd5, 8'h00, "R8");
    do_op(C_WRITE, 4'd2, 8'h00, "R8");
    chk(preload_en == 1'b0, "R11", "lock kept after read/write", preload_en, 0);
    do_op(C_LOCK, 4'd0, 8'h00, "R7");
    do_op(C_ERASE, 4'd0, 8'h00, "R4");
    chk(preload_en == 1'b1, "R11", "lock cleared by erase", preload_en, 1);

    // R9 strobe during an erase sweep is dropped
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_ERASE; cmd_addr = '0; cmd_data = '0;
    @(negedge clk);
    cmd_op = C_WRITE; cmd_addr = 4'd0; cmd_data = 8'h00;
    n = 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    model_erase();
    chk(n == NR, "R9", "busy cycles", n, NR);
    chk_cfg("R9");
    @(negedge clk);
    chk(busy == 1'b0, "R9", "no replay", busy, 0);
    chk(cfg_bits[DW-1:0] == 8'hFF, "R9", "row 0", cfg_bits[DW-1:0], 8'hFF);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int p;
      logic [1:0] op;
      logic [DW-1:0] d;
      p = $urandom_range(0, 99);
      if (p < 5) op = C_ERASE;
      else if (p < 55) op = C_WRITE;
      else if (p < 88) op = C_READ;
      else op = C_LOCK;
      d = DW'($urandom) | DW'($urandom);
      do_op(op, AW'($urandom_range(0, NR - 1)), d, pick_tag(op));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule